// File: doc/BRIEF.md
# Receive Ring Pointer Manager

This block decides where each received record lands in a circular buffer held in host memory. It keeps the write offset into that buffer and a copy of the host's read pointer. It also holds the programmed ring base and ring size. For every record it places, it sends a write command, made of an absolute address and a length, to an external data mover. It keeps a flag that tells the host the ring has drained, and it pulses a receive interrupt request when delivery is tied to an arrival or a rebase.

Records come from an external queue. The block sees whether the queue has a head record and how long that record is. It pops the head with a combinational strobe. New arrivals are offered to it with a valid and a length. With a combinational store strobe it tells the queue whether to keep each arrival. An arrival can instead be placed straight into the ring, or dropped. The host programs the block through a one-cycle register write port. The selector chooses one of three targets: the ring base, the read pointer, or the ring configuration.

Top module: `rxring_ptr_mgr`

## Requirements
- R1: After reset, `wr_offset` is 0x0000, `rd_pointer` is 0xFFF0, `buf_empty` is 1, and both `wr_cmd_valid` and `rx_irq` are 0.
- R2: A write with selector 2 sets the ring size from data bits 12:11. The value 00 gives 8192 bytes, 01 gives 16384, 10 gives 32768 and 11 gives 65536. The new size applies from the next cycle.
- R3: A write with selector 0 loads the ring base from the data. It clears the write offset, sets the read pointer to 0xFFF0 and sets `buf_empty`. If the queue has a head record in that cycle, the record is placed at the new base with `rx_irq`.
- R4: A placed record appears one cycle after its decision as `wr_cmd_valid`, with `wr_cmd_addr` = base + offset and `wr_cmd_len` = the record length. In the same cycle `wr_offset` has advanced by the length, modulo 2^16, and `buf_empty` is 0.
- R5: A write with selector 1 loads `rd_pointer`. When the written value is greater than or equal to the current write offset, the offset is first moved to that value plus 0x10.
- R6: When the read pointer written with selector 1 is greater than the ring size, the write offset becomes 0 and `rx_irq` pulses. No record is placed.
- R7: When a selector 1 write does not exceed the ring size and the queue has a head record, that record is placed without `rx_irq`. If the queue is empty, `buf_empty` is set instead.
- R8: When the offset in use exceeds the ring size, the write command is still issued, but the record is not retired. `q_pop` stays 0 for a head record, and a direct arrival is stored.
- R9: An arrival with no register write in the same cycle, arriving while `buf_empty` is 1, is placed at once with `rx_irq`. The queue head is placed if there is one; otherwise the arrival itself is placed and not stored. When `buf_empty` is 0 the arrival is only stored.
- R10: Arrivals offered before any ring base has been written are discarded: `rec_in_store` stays 0 and nothing is placed.
- R11: An arrival in the same cycle as a register write is stored and never placed directly. The register write alone decides placement.
- R12: `q_pop` and `rec_in_store` are combinational and valid in the decision cycle, so the queue acts on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Target: 0 ring base, 1 read pointer, 2 configuration, 3 none |
| reg_wr_data | input | DATA_W | Register write data |
| rec_in_valid | input | 1 | A new record is offered |
| rec_in_len | input | LEN_W | Length of the offered record in bytes |
| rec_in_store | output | 1 | Queue must keep the offered record |
| q_nonempty | input | 1 | Queue holds a head record |
| q_head_len | input | LEN_W | Length of the queue head record |
| q_pop | output | 1 | Retire the queue head record |
| wr_cmd_valid | output | 1 | Write command to the data mover |
| wr_cmd_addr | output | ADDR_W | Host address of the record |
| wr_cmd_len | output | LEN_W | Record length in bytes |
| rx_irq | output | 1 | One-cycle receive interrupt request |
| buf_empty | output | 1 | Ring has been drained by the host |
| wr_offset | output | OFF_W | Current write offset in the ring |
| rd_pointer | output | OFF_W | Last read pointer written by the host |

## Verification
The bench builds the block with its default parameters: a 32-bit address, 16-bit offsets and lengths, the 0x10 resynchronisation step and ring sizes from 8192 bytes upwards. With the smallest ring size, offsets above the ring end can be reached with a single read-pointer write, so both the wrap path and the unretired placement are exercised. The 16-bit offset also lets the wrap of the offset addition and the 0xFFF0 reset pointer appear at their natural values. A directed sequence covers each rule, followed by a long random mix of register writes and arrivals checked against the bench's own model on every clock.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   typedef enum logic [1:0] {
      RSEL_BASE  = 2'd0,
      RSEL_RDPTR = 2'd1,
      RSEL_CFG   = 2'd2,
      RSEL_NONE  = 2'd3
   } rsel_e;
endpackage

// File: rtl/rxr_size_sel.sv
module rxr_size_sel #(
   parameter int CFG_W    = 2,
   parameter int MIN_LOG2 = 13,
   parameter int RING_W   = 17
) (
   input  logic [CFG_W-1:0]  size_code,
   output logic [RING_W-1:0] ring_bytes
);
   localparam int MAX_LOG2 = MIN_LOG2 + (1 << CFG_W) - 1;

   if (MAX_LOG2 >= RING_W) begin : g_bad_width
      $error("ring size does not fit RING_W");
   end

   always_comb begin
      ring_bytes = RING_W'(1) << (MIN_LOG2 + int'(size_code));
   end
endmodule

// File: rtl/rxr_deliver_ctl.sv
module rxr_deliver_ctl
   import rxr_pkg::*;
#(
   parameter int OFF_W  = 16,
   parameter int LEN_W  = 16,
   parameter int REWIND = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [OFF_W-1:0] wr_ptr,
   input  logic [OFF_W-1:0] off_q,
   input  logic [OFF_W-1:0] rd_q,
   input  logic             empty_q,
   input  logic             base_set_q,
   input  logic [OFF_W:0]   ring_bytes,
   input  logic             q_nonempty,
   input  logic [LEN_W-1:0] q_head_len,
   input  logic             in_valid,
   input  logic [LEN_W-1:0] in_len,
   output logic             do_dlv,
   output logic [OFF_W-1:0] dlv_off,
   output logic [LEN_W-1:0] dlv_len,
   output logic             dlv_irq,
   output logic             wrap_irq,
   output logic             pop,
   output logic             store,
   output logic [OFF_W-1:0] off_nxt,
   output logic [OFF_W-1:0] rd_nxt,
   output logic             empty_nxt
);
   localparam logic [OFF_W-1:0] RD_INIT = {{(OFF_W-4){1'b1}}, 4'h0};

   logic             ptr_over;
   logic [OFF_W-1:0] resync;
   logic             arr_ok;
   logic             bypass;
   logic             retire;

   assign ptr_over = {1'b0, wr_ptr} > ring_bytes;
   assign resync   = (wr_ptr >= off_q) ? wr_ptr + OFF_W'(REWIND) : off_q;
   assign arr_ok   = in_valid & base_set_q;
   assign retire   = !({1'b0, dlv_off} > ring_bytes);

   always_comb begin
      do_dlv    = 1'b0;
      dlv_off   = off_q;
      dlv_len   = q_head_len;
      dlv_irq   = 1'b0;
      wrap_irq  = 1'b0;
      bypass    = 1'b0;
      store     = 1'b0;
      off_nxt   = off_q;
      rd_nxt    = rd_q;
      empty_nxt = empty_q;
      if (wr_en) begin
         store = arr_ok;
         case (wr_sel)
            RSEL_BASE: begin
               off_nxt   = '0;
               rd_nxt    = RD_INIT;
               empty_nxt = 1'b1;
               if (q_nonempty) begin
                  do_dlv  = 1'b1;
                  dlv_off = '0;
                  dlv_irq = 1'b1;
               end
            end
            RSEL_RDPTR: begin
               rd_nxt = wr_ptr;
               if (ptr_over) begin
                  off_nxt  = '0;
                  wrap_irq = 1'b1;
               end else if (q_nonempty) begin
                  do_dlv  = 1'b1;
                  dlv_off = resync;
               end else begin
                  off_nxt   = resync;
                  empty_nxt = 1'b1;
               end
            end
            default: ;
         endcase
      end else if (arr_ok) begin
         store = 1'b1;
         if (empty_q) begin
            do_dlv  = 1'b1;
            dlv_irq = 1'b1;
            if (!q_nonempty) begin
               bypass  = 1'b1;
               dlv_len = in_len;
            end
         end
      end
      pop = 1'b0;
      if (do_dlv) begin
         off_nxt   = dlv_off + OFF_W'(dlv_len);
         empty_nxt = 1'b0;
         pop       = retire & !bypass;
         if (bypass && retire) store = 1'b0;
      end
   end

   // R12: the queue head is retired only when it exists
   p_pop_has_head_r12: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> q_nonempty);
   // R10: no arrival is kept before a ring base exists
   p_discard_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !base_set_q) |-> !store);
   // R8: an offset past the ring end never retires a record
   p_no_retire_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (do_dlv && ({1'b0, dlv_off} > ring_bytes)) |-> !pop);
endmodule

// File: rtl/rxring_ptr_mgr.sv
module rxring_ptr_mgr
   import rxr_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 32,
   parameter int OFF_W    = 16,
   parameter int LEN_W    = 16,
   parameter int REWIND   = 16,
   parameter int CFG_LSB  = 11,
   parameter int CFG_W    = 2,
   parameter int MIN_LOG2 = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [1:0]        reg_wr_sel,
   input  logic [DATA_W-1:0] reg_wr_data,
   input  logic              rec_in_valid,
   input  logic [LEN_W-1:0]  rec_in_len,
   output logic              rec_in_store,
   input  logic              q_nonempty,
   input  logic [LEN_W-1:0]  q_head_len,
   output logic              q_pop,
   output logic              wr_cmd_valid,
   output logic [ADDR_W-1:0] wr_cmd_addr,
   output logic [LEN_W-1:0]  wr_cmd_len,
   output logic              rx_irq,
   output logic              buf_empty,
   output logic [OFF_W-1:0]  wr_offset,
   output logic [OFF_W-1:0]  rd_pointer
);
   localparam int RING_W = OFF_W + 1;
   localparam logic [OFF_W-1:0] RD_INIT = {{(OFF_W-4){1'b1}}, 4'h0};

   if (ADDR_W > DATA_W || OFF_W > DATA_W) begin : g_bad_data
      $error("DATA_W too narrow for address or pointer");
   end
   if (LEN_W > OFF_W || OFF_W < 8) begin : g_bad_len
      $error("LEN_W must not exceed OFF_W, OFF_W at least 8");
   end
   if (CFG_LSB + CFG_W > DATA_W) begin : g_bad_cfg
      $error("configuration field outside data word");
   end

   logic [ADDR_W-1:0] base_q;
   logic              base_set_q;
   logic [CFG_W-1:0]  size_code_q;
   logic [OFF_W-1:0]  off_q, rd_q;
   logic              empty_q;
   logic [RING_W-1:0] ring_bytes;

   logic              do_dlv, dlv_irq, wrap_irq;
   logic [OFF_W-1:0]  dlv_off, off_nxt, rd_nxt;
   logic [LEN_W-1:0]  dlv_len;
   logic              empty_nxt;
   logic              base_wr, cfg_wr;
   logic [ADDR_W-1:0] base_use, dlv_addr;

   assign base_wr  = reg_wr_en && (reg_wr_sel == RSEL_BASE);
   assign cfg_wr   = reg_wr_en && (reg_wr_sel == RSEL_CFG);
   assign base_use = base_wr ? reg_wr_data[ADDR_W-1:0] : base_q;

   rxr_size_sel #(
      .CFG_W(CFG_W), .MIN_LOG2(MIN_LOG2), .RING_W(RING_W)
   ) u_size (
      .size_code (size_code_q),
      .ring_bytes(ring_bytes)
   );

   rxr_deliver_ctl #(
      .OFF_W(OFF_W), .LEN_W(LEN_W), .REWIND(REWIND)
   ) u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (reg_wr_en),
      .wr_sel     (reg_wr_sel),
      .wr_ptr     (reg_wr_data[OFF_W-1:0]),
      .off_q      (off_q),
      .rd_q       (rd_q),
      .empty_q    (empty_q),
      .base_set_q (base_set_q),
      .ring_bytes (ring_bytes),
      .q_nonempty (q_nonempty),
      .q_head_len (q_head_len),
      .in_valid   (rec_in_valid),
      .in_len     (rec_in_len),
      .do_dlv     (do_dlv),
      .dlv_off    (dlv_off),
      .dlv_len    (dlv_len),
      .dlv_irq    (dlv_irq),
      .wrap_irq   (wrap_irq),
      .pop        (q_pop),
      .store      (rec_in_store),
      .off_nxt    (off_nxt),
      .rd_nxt     (rd_nxt),
      .empty_nxt  (empty_nxt)
   );

   if (ADDR_W > OFF_W) begin : g_addr_wide
      assign dlv_addr = base_use + {{(ADDR_W-OFF_W){1'b0}}, dlv_off};
   end else begin : g_addr_narrow
      assign dlv_addr = base_use + dlv_off[ADDR_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q      <= '0;
         base_set_q  <= 1'b0;
         size_code_q <= '0;
         off_q       <= '0;
         rd_q        <= RD_INIT;
         empty_q     <= 1'b1;
         wr_cmd_valid <= 1'b0;
         wr_cmd_addr <= '0;
         wr_cmd_len  <= '0;
         rx_irq      <= 1'b0;
      end else begin
         if (base_wr) begin
            base_q     <= reg_wr_data[ADDR_W-1:0];
            base_set_q <= 1'b1;
         end
         if (cfg_wr) size_code_q <= reg_wr_data[CFG_LSB +: CFG_W];
         off_q        <= off_nxt;
         rd_q         <= rd_nxt;
         empty_q      <= empty_nxt;
         wr_cmd_valid <= do_dlv;
         if (do_dlv) begin
            wr_cmd_addr <= dlv_addr;
            wr_cmd_len  <= dlv_len;
         end
         rx_irq <= (do_dlv & dlv_irq) | wrap_irq;
      end
   end

   assign buf_empty  = empty_q;
   assign wr_offset  = off_q;
   assign rd_pointer = rd_q;

   // R3: a rebase restores the read pointer
   p_base_resets_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      base_wr |=> (rd_pointer == RD_INIT));
   // R4: a placement always clears the drained flag
   p_cmd_clears_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cmd_valid |-> !buf_empty);
   // R4: offset sits right after the record just placed
   p_offset_follows_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cmd_valid |-> (wr_offset == OFF_W'(wr_cmd_addr - base_q) + OFF_W'(wr_cmd_len)));
   // R6: a pointer past the ring end wraps the offset with an interrupt
   p_wrap_zeroes_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && reg_wr_sel == RSEL_RDPTR && ({1'b0, reg_wr_data[OFF_W-1:0]} > ring_bytes))
      |=> (wr_offset == '0 && rx_irq && !wr_cmd_valid));
   // R7: an in-range pointer write with a head record places it quietly
   p_quiet_place_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && reg_wr_sel == RSEL_RDPTR && q_nonempty &&
       !({1'b0, reg_wr_data[OFF_W-1:0]} > ring_bytes))
      |=> (wr_cmd_valid && !rx_irq));
endmodule

// File: tb/tb_rxring_ptr_mgr.sv
`timescale 1ns/1ps
module tb_rxring_ptr_mgr;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [1:0]  reg_wr_sel = 2'd3;
   logic [31:0] reg_wr_data = '0;
   logic        rec_in_valid = 1'b0;
   logic [15:0] rec_in_len = '0;
   logic        rec_in_store;
   logic        q_nonempty = 1'b0;
   logic [15:0] q_head_len = '0;
   logic        q_pop;
   logic        wr_cmd_valid;
   logic [31:0] wr_cmd_addr;
   logic [15:0] wr_cmd_len;
   logic        rx_irq;
   logic        buf_empty;
   logic [15:0] wr_offset;
   logic [15:0] rd_pointer;

   always #2.5 clk = ~clk;

   rxring_ptr_mgr dut (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
      .rec_in_valid(rec_in_valid), .rec_in_len(rec_in_len), .rec_in_store(rec_in_store),
      .q_nonempty(q_nonempty), .q_head_len(q_head_len), .q_pop(q_pop),
      .wr_cmd_valid(wr_cmd_valid), .wr_cmd_addr(wr_cmd_addr), .wr_cmd_len(wr_cmd_len),
      .rx_irq(rx_irq), .buf_empty(buf_empty), .wr_offset(wr_offset), .rd_pointer(rd_pointer)
   );

   int checks = 0;
   int errors = 0;
   int q[$];

   logic [31:0] m_base = '0;
   bit          m_bset = 0;
   logic [15:0] m_off = 16'h0000;
   logic [15:0] m_rd = 16'hFFF0;
   bit          m_empty = 1;
   int          m_size = 8192;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic step(input bit wr, input logic [1:0] sel, input logic [31:0] d,
                       input bit av, input logic [15:0] al, input string tag);
      bit qn, dlv, byp, dirq, ret, arr_ok, e_pop, e_store, e_cv, e_irq;
      logic [15:0] head, doff, dlen, n_off, n_rd, p, rs;
      logic [31:0] n_base, e_addr;
      bit n_bset, n_empty;
      int n_size;
      @(negedge clk);
      qn   = q.size() > 0;
      head = qn ? 16'(q[0]) : 16'h0;
      reg_wr_en = wr; reg_wr_sel = sel; reg_wr_data = d;
      rec_in_valid = av; rec_in_len = al;
      q_nonempty = qn; q_head_len = head;
      #1;
      dlv = 0; byp = 0; dirq = 0; e_pop = 0; e_store = 0; e_cv = 0; e_irq = 0;
      doff = m_off; dlen = head; e_addr = '0;
      n_off = m_off; n_rd = m_rd; n_empty = m_empty; n_base = m_base;
      n_bset = m_bset; n_size = m_size;
      arr_ok = av && m_bset;
      if (wr) begin
         e_store = arr_ok;
         if (sel == 2'd0) begin
            n_base = d; n_bset = 1; n_off = 0; n_rd = 16'hFFF0; n_empty = 1;
            if (qn) begin dlv = 1; doff = 0; dirq = 1; end
         end else if (sel == 2'd1) begin
            p = d[15:0]; n_rd = p;
            rs = (p >= m_off) ? p + 16'h10 : m_off;
            if (int'(p) > m_size) begin n_off = 0; e_irq = 1; end
            else if (qn) begin dlv = 1; doff = rs; end
            else begin n_off = rs; n_empty = 1; end
         end else if (sel == 2'd2) begin
            n_size = 8192 << d[12:11];
         end
      end else if (arr_ok) begin
         e_store = 1;
         if (m_empty) begin
            dlv = 1; dirq = 1;
            if (!qn) begin byp = 1; dlen = al; end
         end
      end
      if (dlv) begin
         ret = !(int'(doff) > m_size);
         e_cv = 1; e_addr = n_base + 32'(doff);
         n_off = doff + dlen; n_empty = 0;
         e_irq = e_irq | dirq;
         e_pop = ret && !byp;
         if (byp && ret) e_store = 0;
      end
      // R12: handshake strobes valid in the decision cycle
      chk(q_pop === e_pop, tag, "q_pop", 32'(q_pop), 32'(e_pop));
      chk(rec_in_store === e_store, tag, "rec_in_store", 32'(rec_in_store), 32'(e_store));
      if (e_pop) void'(q.pop_front());
      if (e_store) q.push_back(int'(al));
      m_off = n_off; m_rd = n_rd; m_empty = n_empty; m_base = n_base;
      m_bset = n_bset; m_size = n_size;
      @(posedge clk); #1;
      chk(wr_cmd_valid === e_cv, tag, "wr_cmd_valid", 32'(wr_cmd_valid), 32'(e_cv));
      if (e_cv) begin
         chk(wr_cmd_addr === e_addr, tag, "wr_cmd_addr", wr_cmd_addr, e_addr);
         chk(wr_cmd_len === dlen, tag, "wr_cmd_len", 32'(wr_cmd_len), 32'(dlen));
      end
      chk(rx_irq === e_irq, tag, "rx_irq", 32'(rx_irq), 32'(e_irq));
      chk(buf_empty === m_empty, tag, "buf_empty", 32'(buf_empty), 32'(m_empty));
      chk(wr_offset === m_off, tag, "wr_offset", 32'(wr_offset), 32'(m_off));
      chk(rd_pointer === m_rd, tag, "rd_pointer", 32'(rd_pointer), 32'(m_rd));
   endtask

   task automatic idle(input string tag);
      step(0, 2'd3, 32'h0, 0, 16'h0, tag);
   endtask

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      // R1 reset state
      chk(wr_offset === 16'h0000, "R1", "wr_offset", 32'(wr_offset), 32'h0);
      chk(rd_pointer === 16'hFFF0, "R1", "rd_pointer", 32'(rd_pointer), 32'hFFF0);
      chk(buf_empty === 1'b1, "R1", "buf_empty", 32'(buf_empty), 32'h1);
      chk(wr_cmd_valid === 1'b0 && rx_irq === 1'b0, "R1", "cmd/irq", 32'(wr_cmd_valid), 32'h0);

      step(0, 2'd3, 0, 1, 16'd64, "R10");             // no base yet: dropped
      step(1, 2'd0, 32'h1000_0000, 0, 0, "R3");        // rebase, empty queue
      step(0, 2'd3, 0, 1, 16'd64, "R9");               // direct placement at base
      step(0, 2'd3, 0, 1, 16'd100, "R9");              // flag clear: store only
      step(1, 2'd1, 32'h0030, 0, 0, "R7");             // quiet placement at 64
      step(1, 2'd1, 32'h00B0, 0, 0, "R5");             // resync to 0xC0, empty set
      step(1, 2'd1, 32'h2100, 0, 0, "R6");             // past 8192: wrap
      step(1, 2'd2, 32'h0000_0800, 0, 0, "R2");        // 16384 bytes
      step(1, 2'd1, 32'h2100, 0, 0, "R2");             // now in range: resync
      step(1, 2'd2, 32'h0000_1800, 0, 0, "R2");        // 65536 bytes
      step(1, 2'd1, 32'hFFF0, 0, 0, "R2");             // never past the ring
      step(1, 2'd2, 32'h0000_0000, 0, 0, "R2");        // back to 8192
      step(1, 2'd1, 32'h2000, 0, 0, "R8");             // offset 0x2010 > ring
      step(0, 2'd3, 0, 1, 16'd32, "R8");               // placed, not retired: stored
      step(1, 2'd1, 32'h0000, 1, 16'd48, "R11");       // head placed, arrival queued
      step(1, 2'd0, 32'h2000_0040, 0, 0, "R3");        // rebase with pending head
      step(1, 2'd1, 32'h0000, 0, 0, "R4");             // drain next record
      idle("R4");

      for (int i = 0; i < 2000; i++) begin
         int op = $urandom_range(0, 19);
         logic [31:0] d;
         bit av = ($urandom_range(0, 2) == 0);
         logic [15:0] al = 16'($urandom_range(60, 1600));
         if (op == 0) step(1, 2'd0, $urandom, av, al, "R3");
         else if (op == 1) begin
            d = 32'($urandom_range(0, 3)) << 11;
            step(1, 2'd2, d, av, al, "R2");
         end else if (op < 7) begin
            if ($urandom_range(0, 1) == 1) d = 32'(wr_offset) + 32'($urandom_range(0, 64)) - 32;
            else d = 32'($urandom_range(0, 16'hFFFF));
            step(1, 2'd1, d, av, al, "R5");
         end else step(0, 2'd3, 0, av, al, "R9");
      end
      idle("R4");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule